// File: doc/BRIEF.md
# Clear-on-Read Statistics Counter Bank

This block holds a small set of 32-bit statistics counters for one MAC port. Event counters each take a one-bit pulse per cycle and add one. Length counters each take a valid strobe and a 16-bit byte count, and add that count. Software reads a counter through a simple strobe-and-address port. The value comes back one cycle later, and the same read empties the counter, so every read returns the activity since the previous read.

A configuration bit selects a test mode. In that mode a read does not clear the counter. It loads the counter with a value just below the carry into bit 31 instead. Event counters get one preset and length counters a lower one, so that a few events or bytes take the counter across that boundary. This lets software check its own overflow handling in a few steps instead of billions of events. Counters never saturate. They run modulo 2^32.

Top module: `stats_cnt_bank`

## Requirements
- R1: A read with `rd_en` high presents the addressed counter's value on `rd_data` with `rd_valid` high on the next cycle. `rd_valid` is low in the cycle after any cycle without `rd_en`.
- R2: With test mode off, a read leaves the counter at zero. This holds when no event hits that counter in the same cycle.
- R3: With test mode on, a read of an event counter (addresses 0 to N_EVT-1) leaves it at 0x7FFF_FFFC.
- R4: With test mode on, a read of a length counter (addresses N_EVT to N_EVT+N_LEN-1) leaves it at 0x7FFF_FF80.
- R5: Test mode is off after reset. It is written from `cfg_test_mode` in a cycle with `cfg_wr_en` high and takes effect for reads from the next cycle on.
- R6: An event counter adds exactly one per cycle in which its `evt_inc` bit is high. It counts modulo 2^32 without saturating, so 0x7FFF_FFFC plus 4 gives 0x8000_0000.
- R7: A length counter adds its 16-bit field of `len_bytes` (bits [16j+15:16j] for length counter j) in each cycle its `len_vld` bit is high. It counts modulo 2^32.
- R8: When a read and an event hit the same counter in the same cycle, the read returns the value before the event. The counter then holds the cleared or preset value plus that event's increment.
- R9: A read changes only the addressed counter. A read at an address of N_EVT+N_LEN or above returns zero and changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the test-mode bit |
| cfg_test_mode | input | 1 | New test-mode value |
| evt_inc | input | N_EVT | One increment pulse per event counter |
| len_vld | input | N_LEN | Add strobe per length counter |
| len_bytes | input | N_LEN*LEN_W | Byte counts, LEN_W bits per length counter |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Counter address |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | CNT_W | Value read |

## Verification
A read-and-clear and an event update can land on the same counter in one cycle. That is the case where a careless design loses a count or returns a post-increment value. The bench provokes it directly: it reads event and length counters while pulsing their inputs, in both normal and test mode. It also hits it often during random traffic, because the random stimulus draws reads and events independently each cycle. A reference model judges each such cycle: the returned value must be the model's pre-update count, and a later read must show the clear or preset value plus exactly that increment.

// File: rtl/stats_pkg.sv
package stats_pkg;
    // kind of a counter slot, selects its test-mode preset
    typedef enum logic {
        KIND_EVENT  = 1'b0,
        KIND_LENGTH = 1'b1
    } cnt_kind_e;

    // distance of the test-mode preset below the carry into the top bit
    localparam int EVT_GAP = 4;
    localparam int LEN_GAP = 128;
endpackage

// File: rtl/stats_cnt_slot.sv
module stats_cnt_slot
    import stats_pkg::*;
#(
    parameter int        CNT_W = 32,
    parameter int        LEN_W = 16,
    parameter cnt_kind_e KIND  = KIND_EVENT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump_i,
    input  logic [LEN_W-1:0] amount_i,
    input  logic             rd_hit_i,
    input  logic             test_i,
    output logic [CNT_W-1:0] value_o
);
    localparam logic [CNT_W-1:0] HALF   = CNT_W'(1) << (CNT_W - 1);
    localparam int               GAP    = (KIND == KIND_LENGTH) ? LEN_GAP : EVT_GAP;
    localparam logic [CNT_W-1:0] PRESET = HALF - CNT_W'(GAP);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } slot_t;

    slot_t            st_d, st_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] step;

    always_comb begin
        st_d = st_q;
        step = bump_i ? CNT_W'(amount_i) : '0;
        if (rd_hit_i) begin
            base = test_i ? PRESET : '0;
        end else begin
            base = st_q.cnt;
        end
        st_d.cnt = base + step;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value_o = st_q.cnt;
endmodule

// File: rtl/stats_rd_port.sv
module stats_rd_port #(
    parameter int NUM    = 8,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [NUM*CNT_W-1:0] cnt_flat,
    output logic [NUM-1:0]     hit_o,
    output logic               rd_valid,
    output logic [CNT_W-1:0]   rd_data
);
    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = rd_en;
        rd_d.data  = '0;
        hit_o      = '0;
        for (int i = 0; i < NUM; i++) begin
            if (rd_en && (rd_addr == ADDR_W'(i))) begin
                hit_o[i]  = 1'b1;
                rd_d.data = cnt_flat[i*CNT_W +: CNT_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;
endmodule

// File: rtl/stats_cnt_bank.sv
module stats_cnt_bank
    import stats_pkg::*;
#(
    parameter int N_EVT  = 5,
    parameter int N_LEN  = 3,
    parameter int CNT_W  = 32,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr_en,
    input  logic                   cfg_test_mode,
    input  logic [N_EVT-1:0]       evt_inc,
    input  logic [N_LEN-1:0]       len_vld,
    input  logic [N_LEN*LEN_W-1:0] len_bytes,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic                   rd_valid,
    output logic [CNT_W-1:0]       rd_data
);
    localparam int N_TOT = N_EVT + N_LEN;

    typedef struct packed {
        logic test;
    } cfg_t;

    cfg_t                   cfg_d, cfg_q;
    logic [N_TOT-1:0]       slot_hit;
    logic [N_TOT-1:0]       slot_bump;
    logic [N_TOT*CNT_W-1:0] slot_val;
    logic                   test_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr_en) begin
            cfg_d.test = cfg_test_mode;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign test_q    = cfg_q.test;
    assign slot_bump = {len_vld, evt_inc};

    for (genvar i = 0; i < N_EVT; i++) begin : g_evt
        stats_cnt_slot #(
            .CNT_W (CNT_W),
            .LEN_W (LEN_W),
            .KIND  (KIND_EVENT)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .bump_i   (evt_inc[i]),
            .amount_i (LEN_W'(1)),
            .rd_hit_i (slot_hit[i]),
            .test_i   (test_q),
            .value_o  (slot_val[i*CNT_W +: CNT_W])
        );
    end

    for (genvar j = 0; j < N_LEN; j++) begin : g_len
        stats_cnt_slot #(
            .CNT_W (CNT_W),
            .LEN_W (LEN_W),
            .KIND  (KIND_LENGTH)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .bump_i   (len_vld[j]),
            .amount_i (len_bytes[j*LEN_W +: LEN_W]),
            .rd_hit_i (slot_hit[N_EVT+j]),
            .test_i   (test_q),
            .value_o  (slot_val[(N_EVT+j)*CNT_W +: CNT_W])
        );
    end

    stats_rd_port #(
        .NUM    (N_TOT),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .cnt_flat (slot_val),
        .hit_o    (slot_hit),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/stats_cnt_bank_chk.sv
module stats_cnt_bank_chk #(
    parameter int N_EVT = 5,
    parameter int N_LEN = 3,
    parameter int CNT_W = 32,
    parameter int LEN_W = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         rd_en,
    input logic                         rd_valid,
    input logic                         test_q,
    input logic [N_EVT+N_LEN-1:0]       slot_hit,
    input logic [N_EVT+N_LEN-1:0]       slot_bump,
    input logic [(N_EVT+N_LEN)*CNT_W-1:0] slot_val,
    input logic [N_LEN*LEN_W-1:0]       len_bytes
);
    localparam logic [CNT_W-1:0] TOP_MINUS1 = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] EVT_PRE    = TOP_MINUS1 - CNT_W'(3);
    localparam logic [CNT_W-1:0] LEN_PRE    = TOP_MINUS1 - CNT_W'(127);

    AST_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R1
    AST_RD_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R1
    AST_ONE_SLOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_hit)); // R9

    for (genvar i = 0; i < N_EVT + N_LEN; i++) begin : g_any
        AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_hit[i] && !test_q && !slot_bump[i]) |=> (slot_val[i*CNT_W +: CNT_W] == '0)); // R2
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!slot_hit[i] && !slot_bump[i]) |=> $stable(slot_val[i*CNT_W +: CNT_W])); // R9
    end

    for (genvar i = 0; i < N_EVT; i++) begin : g_evt
        AST_EVT_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_hit[i] && test_q && !slot_bump[i]) |=> (slot_val[i*CNT_W +: CNT_W] == EVT_PRE)); // R3
        AST_EVT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (!slot_hit[i] && slot_bump[i]) |=>
            (slot_val[i*CNT_W +: CNT_W] == $past(slot_val[i*CNT_W +: CNT_W]) + CNT_W'(1))); // R6
        AST_EVT_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_hit[i] && slot_bump[i]) |=>
            (slot_val[i*CNT_W +: CNT_W] == ($past(test_q) ? EVT_PRE : '0) + CNT_W'(1))); // R8
    end

    for (genvar j = 0; j < N_LEN; j++) begin : g_len
        AST_LEN_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_hit[N_EVT+j] && test_q && !slot_bump[N_EVT+j]) |=>
            (slot_val[(N_EVT+j)*CNT_W +: CNT_W] == LEN_PRE)); // R4
        AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (!slot_hit[N_EVT+j] && slot_bump[N_EVT+j]) |=>
            (slot_val[(N_EVT+j)*CNT_W +: CNT_W] ==
             $past(slot_val[(N_EVT+j)*CNT_W +: CNT_W]) + CNT_W'($past(len_bytes[j*LEN_W +: LEN_W])))); // R7
    end
endmodule

bind stats_cnt_bank stats_cnt_bank_chk #(
    .N_EVT (N_EVT),
    .N_LEN (N_LEN),
    .CNT_W (CNT_W),
    .LEN_W (LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_valid  (rd_valid),
    .test_q    (test_q),
    .slot_hit  (slot_hit),
    .slot_bump (slot_bump),
    .slot_val  (slot_val),
    .len_bytes (len_bytes)
);

// File: tb/stats_cnt_bank_test.sv
`timescale 1ns/1ps
module stats_cnt_bank_test;
    localparam int NE = 5;
    localparam int NL = 3;
    localparam int NT = NE + NL;
    localparam int AW = 4;
    localparam int LW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr_en = 1'b0;
    logic              cfg_test_mode = 1'b0;
    logic [NE-1:0]     evt_inc = '0;
    logic [NL-1:0]     len_vld = '0;
    logic [NL*LW-1:0]  len_bytes = '0;
    logic              rd_en = 1'b0;
    logic [AW-1:0]     rd_addr = '0;
    logic              rd_valid;
    logic [31:0]       rd_data;

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [31:0] model [NT];
    logic        m_test = 1'b0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    stats_cnt_bank #(.N_EVT(NE), .N_LEN(NL), .CNT_W(32), .LEN_W(LW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_test_mode(cfg_test_mode),
        .evt_inc(evt_inc), .len_vld(len_vld), .len_bytes(len_bytes),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [31:0] preset_of(int idx, logic tm);
        if (!tm) return 32'h0;
        return (idx < NE) ? 32'h7FFF_FFFC : 32'h7FFF_FF80;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // entered at a negedge; drives one cycle, checks its read result at the next negedge
    task automatic cyc(string tag, bit rd, int addr, logic [NE-1:0] ev,
                       logic [NL-1:0] lv, logic [NL*LW-1:0] lb, bit cw, bit cv);
        logic [31:0] exp_data;
        logic [31:0] base;
        logic [31:0] add;
        rd_en = rd; rd_addr = AW'(addr); evt_inc = ev; len_vld = lv; len_bytes = lb;
        cfg_wr_en = cw; cfg_test_mode = cv;
        exp_data = (rd && addr < NT) ? model[addr] : 32'h0;
        for (int i = 0; i < NT; i++) begin
            base = (rd && addr == i) ? preset_of(i, m_test) : model[i];
            if (i < NE) add = {31'h0, ev[i]};
            else add = lv[i-NE] ? {16'h0, lb[(i-NE)*LW +: LW]} : 32'h0;
            model[i] = base + add;
        end
        if (cw) m_test = cv;
        @(posedge clk);
        @(negedge clk);
        check({tag, " valid"}, {31'h0, rd_valid}, {31'h0, rd});
        if (rd) check(tag, rd_data, exp_data);
    endtask

    task automatic idle();
        cyc("R1", 0, 0, '0, '0, '0, 0, 0);
    endtask

    task automatic rd_at(string tag, int addr);
        cyc(tag, 1, addr, '0, '0, '0, 0, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [NE-1:0] ev;
        logic [NL-1:0] lv;
        logic [NL*LW-1:0] lb;
        bit rd, cw, cv;
        int addr;
        string tag;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < NT; i++) model[i] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R5 reset valid", {31'h0, rd_valid}, 32'h0);
        check("R5 reset data", rd_data, 32'h0);
        rst_n = 1'b1;

        // R5: test mode off after reset -> two reads of a counter give zero
        rd_at("R5", 0);
        rd_at("R5", 0);
        rd_at("R5", NE);

        // R6 / R2: three events, read, read again
        for (int k = 0; k < 3; k++) cyc("R6", 0, 0, 5'b00010, '0, '0, 0, 0);
        rd_at("R6", 1);
        rd_at("R2", 1);

        // R7: byte accumulation on length counter 1
        cyc("R7", 0, 0, '0, 3'b010, {16'h0, 16'd1500, 16'h0}, 0, 0);
        cyc("R7", 0, 0, '0, 3'b010, {16'h0, 16'd64, 16'h0}, 0, 0);
        rd_at("R7", NE + 1);

        // R5 / R3 / R4: enable test mode, read to preset, read back
        cyc("R5", 0, 0, '0, '0, '0, 1, 1);
        rd_at("R3", 2);
        rd_at("R3", 2);
        for (int k = 0; k < 4; k++) cyc("R6", 0, 0, 5'b00100, '0, '0, 0, 0);
        rd_at("R6", 2);
        rd_at("R4", NE + 2);
        rd_at("R4", NE + 2);
        cyc("R7", 0, 0, '0, 3'b100, {16'h0100, 32'h0}, 0, 0);
        rd_at("R7", NE + 2);

        // R8: read and event on the same counter, test mode on
        cyc("R8", 0, 0, 5'b01000, '0, '0, 0, 0);
        cyc("R8", 1, 3, 5'b01000, '0, '0, 0, 0);
        rd_at("R8", 3);
        cyc("R8", 1, NE, '0, 3'b001, {32'h0, 16'd77}, 0, 0);
        rd_at("R8", NE);

        // R8 with test mode off
        cyc("R5", 0, 0, '0, '0, '0, 1, 0);
        cyc("R8", 0, 0, 5'b00001, '0, '0, 0, 0);
        cyc("R8", 1, 0, 5'b00001, '0, '0, 0, 0);
        rd_at("R8", 0);

        // R9: out-of-range read returns zero and disturbs nothing; other reads leave neighbours
        cyc("R9", 0, 0, 5'b10000, 3'b010, {16'h0, 16'd9, 16'h0}, 0, 0);
        rd_at("R9", 12);
        rd_at("R9", 15);
        rd_at("R9", 3);
        rd_at("R9", 4);
        rd_at("R9", NE + 1);
        idle();

        // constrained random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            rd   = ($urandom % 100) < 45;
            addr = $urandom % 12;
            ev   = NE'($urandom);
            lv   = NL'($urandom);
            lb   = {16'($urandom), 16'($urandom), 16'($urandom)};
            cw   = ($urandom % 100) < 4;
            cv   = 1'($urandom);
            tag  = "R1";
            if (rd && addr < NE && ev[addr]) tag = "R8";
            if (rd && addr >= NE && addr < NT && lv[addr-NE]) tag = "R8";
            if (rd && addr >= NT) tag = "R9";
            cyc(tag, rd, addr, ev, lv, lb, cw, cv);
        end

        // drain: read every counter once more
        for (int i = 0; i < NT; i++) rd_at("R2", i);
        idle();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule